// File: doc/BRIEF.md
# MESI Snooping Cache Coherence Controller

This block keeps one direct-mapped, write-back data cache coherent with its peers on a shared snooping bus. Each line carries one of four states: Modified (dirty, only copy), Exclusive (clean, only copy), Shared (clean, other copies may exist) and Invalid. Processor loads and stores that hit a line in a state that permits the access complete locally. All other accesses become transactions on the bus, which orders every coherence action. The transaction types are read line, write line, read-and-invalidate line, and invalidate line.

At the same time the controller watches the transactions of other caches on a snoop port. It answers a remote read with a shared indication and, when it holds the only dirty copy, supplies that data. It drops its copy when another cache claims ownership. A fill samples the bus shared signal to decide between Exclusive and Shared. Because the read-and-invalidate and the dataless invalidate are separate operations, a write to an Exclusive line upgrades without any bus traffic, and a write to a Shared line upgrades without moving data.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid. A snoop to any address gets no shared or flush response, and the first access to any address goes to the bus.
- R2: A read miss issues read line (bm_cmd code 1) with the requested address and returns the bus data on cpu_rdata. With bm_shared_in low the line fills to Exclusive.
- R3: A read miss filled while bm_shared_in is high leaves the line Shared, so that a later write to it issues invalidate line (code 4).
- R4: A write miss issues read-and-invalidate line (code 3) and fills to Modified holding the written data.
- R5: A write that hits an Exclusive line completes with no bus transaction and leaves the line Modified.
- R6: A write that hits a Shared line issues invalidate line (code 4) at the requested address and leaves the line Modified.
- R7: Reads that hit any valid state, and writes that hit Modified, complete with no bus transaction and return the stored data.
- R8: A snooped read line (code 1) that hits a Modified line raises sn_shared and sn_flush with the line data on sn_data, and the line becomes Shared.
- R9: A snooped read line that hits an Exclusive or Shared line raises sn_shared without sn_flush. An Exclusive line becomes Shared.
- R10: A snooped read-and-invalidate (code 3) or invalidate (code 4) that hits a valid line makes it Invalid. A Modified line raises sn_flush with its data in that cycle. sn_shared stays low for these codes.
- R11: A miss whose direct-mapped slot holds a Modified line with another tag first issues write line (code 2) with the victim address and data, then the fill request.
- R12: A snoop whose tag does not match a valid line, and any snooped write line, gets no response and changes no line.
- R13: bm_req stays low in every cycle that sn_valid is high. A pending Shared-line upgrade whose copy is invalidated by a snoop is reissued as read-and-invalidate.
- R14: Each accepted processor request raises cpu_done for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, accepted when the controller is idle |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W | Line address; the low IDX_W bits select the slot |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result, valid while cpu_done is high |
| bm_req | output | 1 | Bus master request |
| bm_cmd | output | 3 | Bus operation: 1 read, 2 write, 3 read-and-invalidate, 4 invalidate |
| bm_addr | output | ADDR_W | Bus operation address |
| bm_wdata | output | DATA_W | Write-back data |
| bm_gnt | input | 1 | The requested operation takes place in this cycle |
| bm_rdata | input | DATA_W | Fill data, valid with bm_gnt |
| bm_shared_in | input | 1 | Another cache holds the line, valid with bm_gnt |
| sn_valid | input | 1 | A remote transaction is on the bus |
| sn_cmd | input | 3 | Remote operation code, same encoding as bm_cmd |
| sn_addr | input | ADDR_W | Remote operation address |
| sn_shared | output | 1 | This cache holds the line being read |
| sn_flush | output | 1 | This cache supplies its dirty data |
| sn_data | output | DATA_W | Supplied data |

## Verification
The hardest situation to reach is a snoop that arrives while a request is already waiting for the bus. The case that matters is a Shared-line upgrade whose copy is invalidated before the grant. The bench first builds a Shared line through a fill with the shared signal high. It then issues a store and, while bm_req is up for the invalidate, drives a remote invalidate to the same address. It watches the request drop during the snoop and come back as read-and-invalidate. The other flows are swept over every slot with two and three competing tags, so that write-backs of victims and every state move can be seen.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_st_t;

  typedef enum logic [2:0] {
    BX_NONE = 3'd0,
    BX_RD   = 3'd1,
    BX_WR   = 3'd2,
    BX_RDX  = 3'd3,
    BX_INV  = 3'd4
  } bus_op_t;

  // state a line takes after a remote operation hits it
  function automatic line_st_t snoop_next(input line_st_t cur, input bus_op_t op);
    line_st_t r;
    r = cur;
    case (op)
      BX_RD:          if (cur == LS_M || cur == LS_E) r = LS_S;
      BX_RDX, BX_INV: r = LS_I;
      default:        r = cur;
    endcase
    return r;
  endfunction

  function automatic logic snoop_shared(input line_st_t cur, input bus_op_t op);
    return (op == BX_RD) && (cur != LS_I);
  endfunction

  function automatic logic snoop_flush(input line_st_t cur, input bus_op_t op);
    return (cur == LS_M) && (op == BX_RD || op == BX_RDX || op == BX_INV);
  endfunction

  function automatic line_st_t fill_state(input logic is_wr, input logic shared);
    line_st_t r;
    if (is_wr)       r = LS_M;
    else if (shared) r = LS_S;
    else             r = LS_E;
    return r;
  endfunction

  // operation for a request that cannot complete locally
  function automatic bus_op_t miss_op(input logic is_wr, input logic present);
    bus_op_t r;
    if (present)    r = BX_INV;
    else if (is_wr) r = BX_RDX;
    else            r = BX_RD;
    return r;
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  output line_st_t          lk_st,
  output logic [DATA_W-1:0] lk_data,
  input  logic [IDX_W-1:0]  sp_idx,
  output logic [TAG_W-1:0]  sp_tag,
  output line_st_t          sp_st,
  output logic [DATA_W-1:0] sp_data,
  input  logic              fw_en,
  input  logic [IDX_W-1:0]  fw_idx,
  input  logic [TAG_W-1:0]  fw_tag,
  input  line_st_t          fw_st,
  input  logic [DATA_W-1:0] fw_data,
  input  logic              ss_en,
  input  logic [IDX_W-1:0]  ss_idx,
  input  line_st_t          ss_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        st_q[g] <= LS_I;
      else if (ss_en && ss_idx == IDX_W'(g))
        st_q[g] <= ss_st;
      else if (fw_en && fw_idx == IDX_W'(g))
        st_q[g] <= fw_st;
    end

    always_ff @(posedge clk) begin
      if (fw_en && fw_idx == IDX_W'(g)) begin
        tag_q[g] <= fw_tag;
        dat_q[g] <= fw_data;
      end
    end
  end

  assign lk_tag  = tag_q[lk_idx];
  assign lk_st   = st_q[lk_idx];
  assign lk_data = dat_q[lk_idx];
  assign sp_tag  = tag_q[sp_idx];
  assign sp_st   = st_q[sp_idx];
  assign sp_data = dat_q[sp_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              sn_valid,
  input  bus_op_t           sn_op,
  input  logic [TAG_W-1:0]  sn_tag,
  input  logic [TAG_W-1:0]  line_tag,
  input  line_st_t          line_st,
  input  logic [DATA_W-1:0] line_data,
  output logic              hit,
  output logic              shared_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] data_o,
  output logic              upd_en,
  output line_st_t          upd_st
);
  assign hit      = sn_valid && (line_st != LS_I) && (line_tag == sn_tag);
  assign shared_o = hit && snoop_shared(line_st, sn_op);
  assign flush_o  = hit && snoop_flush(line_st, sn_op);
  assign data_o   = flush_o ? line_data : '0;
  assign upd_st   = snoop_next(line_st, sn_op);
  assign upd_en   = hit && (upd_st != line_st);
endmodule

// File: rtl/mesi_proc_fsm.sv
module mesi_proc_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_done,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic [IDX_W-1:0]        lk_idx,
  input  logic [ADDR_W-IDX_W-1:0] lk_tag,
  input  line_st_t                lk_st,
  input  logic [DATA_W-1:0]       lk_data,
  input  logic                    sn_valid,
  output logic                    bm_req,
  output bus_op_t                 bm_op,
  output logic [ADDR_W-1:0]       bm_addr,
  output logic [DATA_W-1:0]       bm_wdata,
  input  logic                    bm_gnt,
  input  logic [DATA_W-1:0]       bm_rdata,
  input  logic                    bm_shared_in,
  output logic                    fw_en,
  output logic [ADDR_W-IDX_W-1:0] fw_tag,
  output line_st_t                fw_st,
  output logic [DATA_W-1:0]       fw_data,
  output logic                    ev_hit_done,
  output logic                    ev_victim_wb,
  output logic                    ev_fill
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              busy_q, we_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q, rdata_q;
  logic [TAG_W-1:0]  rq_tag;
  logic              tag_match, dirty_victim, hit_ok, need_bus, act;

  assign rq_tag = addr_q[ADDR_W-1:IDX_W];
  assign lk_idx = addr_q[IDX_W-1:0];

  assign tag_match    = (lk_st != LS_I) && (lk_tag == rq_tag);
  assign dirty_victim = (lk_st == LS_M) && (lk_tag != rq_tag);
  assign hit_ok       = tag_match && (!we_q || lk_st == LS_E || lk_st == LS_M);
  assign act          = busy_q && !sn_valid;
  assign need_bus     = busy_q && !hit_ok;

  assign bm_req   = need_bus && !sn_valid;
  assign bm_op    = dirty_victim ? BX_WR : miss_op(we_q, tag_match);
  assign bm_addr  = dirty_victim ? {lk_tag, lk_idx} : addr_q;
  assign bm_wdata = lk_data;

  assign ev_hit_done  = act && hit_ok;
  assign ev_victim_wb = bm_req && bm_gnt && dirty_victim;
  assign ev_fill      = bm_req && bm_gnt && !dirty_victim;

  always_comb begin
    fw_en   = 1'b0;
    fw_tag  = lk_tag;
    fw_st   = lk_st;
    fw_data = lk_data;
    if (ev_victim_wb) begin
      fw_en = 1'b1;
      fw_st = LS_I;
    end else if (ev_fill) begin
      fw_en   = 1'b1;
      fw_tag  = rq_tag;
      fw_st   = fill_state(we_q, bm_shared_in);
      fw_data = we_q ? wd_q : bm_rdata;
    end else if (ev_hit_done && we_q) begin
      fw_en   = 1'b1;
      fw_st   = LS_M;
      fw_data = wd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= ev_hit_done || ev_fill;
      if (!busy_q && cpu_req) begin
        busy_q <= 1'b1;
        we_q   <= cpu_we;
        addr_q <= cpu_addr;
        wd_q   <= cpu_wdata;
      end else if (ev_hit_done || ev_fill) begin
        busy_q <= 1'b0;
      end
      if (ev_hit_done) rdata_q <= we_q ? wd_q : lk_data;
      else if (ev_fill) rdata_q <= we_q ? wd_q : bm_rdata;
    end
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bm_req,
  output logic [2:0]        bm_cmd,
  output logic [ADDR_W-1:0] bm_addr,
  output logic [DATA_W-1:0] bm_wdata,
  input  logic              bm_gnt,
  input  logic [DATA_W-1:0] bm_rdata,
  input  logic              bm_shared_in,
  input  logic              sn_valid,
  input  logic [2:0]        sn_cmd,
  input  logic [ADDR_W-1:0] sn_addr,
  output logic              sn_shared,
  output logic              sn_flush,
  output logic [DATA_W-1:0] sn_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag, sp_tag, fw_tag;
  line_st_t          lk_st, sp_st, fw_st, ss_st;
  logic [DATA_W-1:0] lk_data, sp_data, fw_data;
  logic              fw_en, ss_en, sn_hit;
  logic              ev_hit_done, ev_victim_wb, ev_fill;
  bus_op_t           bm_op, sn_op;

  assign sn_op  = bus_op_t'(sn_cmd);
  assign bm_cmd = bm_op;

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_st(lk_st), .lk_data(lk_data),
    .sp_idx(sn_addr[IDX_W-1:0]), .sp_tag(sp_tag), .sp_st(sp_st), .sp_data(sp_data),
    .fw_en(fw_en), .fw_idx(lk_idx), .fw_tag(fw_tag), .fw_st(fw_st), .fw_data(fw_data),
    .ss_en(ss_en), .ss_idx(sn_addr[IDX_W-1:0]), .ss_st(ss_st)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .sn_valid(sn_valid), .sn_op(sn_op), .sn_tag(sn_addr[ADDR_W-1:IDX_W]),
    .line_tag(sp_tag), .line_st(sp_st), .line_data(sp_data),
    .hit(sn_hit), .shared_o(sn_shared), .flush_o(sn_flush), .data_o(sn_data),
    .upd_en(ss_en), .upd_st(ss_st)
  );

  mesi_proc_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_st(lk_st), .lk_data(lk_data),
    .sn_valid(sn_valid),
    .bm_req(bm_req), .bm_op(bm_op), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
    .bm_gnt(bm_gnt), .bm_rdata(bm_rdata), .bm_shared_in(bm_shared_in),
    .fw_en(fw_en), .fw_tag(fw_tag), .fw_st(fw_st), .fw_data(fw_data),
    .ev_hit_done(ev_hit_done), .ev_victim_wb(ev_victim_wb), .ev_fill(ev_fill)
  );
endmodule

// File: rtl/mesi_ctrl_checker.sv
module mesi_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_done,
  input logic       bm_req,
  input logic [2:0] bm_cmd,
  input logic       bm_gnt,
  input logic       sn_valid,
  input logic [2:0] sn_cmd,
  input logic       sn_shared,
  input logic       sn_flush,
  input logic       sn_hit,
  input logic       ev_hit_done,
  input logic       ev_victim_wb,
  input logic       ev_fill
);
  // R14
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  // R13
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sn_valid |-> !bm_req);

  // R12
  snoop_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sn_valid && sn_cmd == 3'd2) |-> (!sn_shared && !sn_flush));

  // R8
  flush_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sn_flush && sn_cmd == 3'd1) |-> sn_shared);

  // R10
  inval_no_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sn_valid && (sn_cmd == 3'd3 || sn_cmd == 3'd4)) |-> !sn_shared);

  // R12
  resp_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sn_shared || sn_flush) |-> sn_hit);

  // R11
  victim_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_victim_wb |-> (bm_cmd == 3'd2 && bm_gnt));

  // R2
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> cpu_done);

  // R7
  hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit_done |-> !bm_req);
endmodule

bind snoop_cache_ctrl mesi_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .bm_req(bm_req), .bm_cmd(bm_cmd),
  .bm_gnt(bm_gnt), .sn_valid(sn_valid), .sn_cmd(sn_cmd), .sn_shared(sn_shared),
  .sn_flush(sn_flush), .sn_hit(sn_hit), .ev_hit_done(ev_hit_done),
  .ev_victim_wb(ev_victim_wb), .ev_fill(ev_fill)
);

// File: tb/test_snoop_cache_ctrl.sv
module test_snoop_cache_ctrl;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 2;
  localparam int DATA_W = 8;
  localparam logic [2:0] C_RD = 3'd1, C_WR = 3'd2, C_RDX = 3'd3, C_INV = 3'd4;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req, cpu_we;
  logic [7:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic cpu_done;
  logic bm_req, bm_gnt, bm_shared_in;
  logic [2:0] bm_cmd;
  logic [7:0] bm_addr, bm_wdata, bm_rdata;
  logic sn_valid, sn_shared, sn_flush;
  logic [2:0] sn_cmd;
  logic [7:0] sn_addr, sn_data;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mem [256];
  logic [2:0] lg_cmd [8];
  logic [7:0] lg_addr [8];
  logic [7:0] lg_data [8];
  int n_tx;
  logic [7:0] last_rd;

  always #5 clk = ~clk;

  snoop_cache_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_snoop_cache_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bm_req(bm_req), .bm_cmd(bm_cmd), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
    .bm_gnt(bm_gnt), .bm_rdata(bm_rdata), .bm_shared_in(bm_shared_in),
    .sn_valid(sn_valid), .sn_cmd(sn_cmd), .sn_addr(sn_addr),
    .sn_shared(sn_shared), .sn_flush(sn_flush), .sn_data(sn_data)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // drive one processor request and act as bus and memory until it completes
  task automatic cpu_op(input bit we, input logic [7:0] a, input logic [7:0] wd, input bit shr);
    bit got;
    got  = 1'b0;
    n_tx = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    for (int k = 0; k < 40 && !got; k++) begin
      if (cpu_done) begin
        got = 1'b1;
        last_rd = cpu_rdata;
        @(negedge clk);
        chk("R14 done pulse length", int'(cpu_done), 0);
      end else if (bm_req) begin
        if (n_tx < 8) begin
          lg_cmd[n_tx]  = bm_cmd;
          lg_addr[n_tx] = bm_addr;
          lg_data[n_tx] = bm_wdata;
        end
        bm_gnt = 1'b1; bm_rdata = mem[bm_addr]; bm_shared_in = shr;
        if (bm_cmd == C_WR) mem[bm_addr] = bm_wdata;
        n_tx++;
        @(negedge clk);
        bm_gnt = 1'b0; bm_shared_in = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk("R14 request completes", int'(got), 1);
  endtask

  task automatic snoop(input logic [2:0] c, input logic [7:0] a, input bit exp_sh,
                       input bit exp_fl, input logic [7:0] exp_d, input string rq);
    @(negedge clk);
    sn_valid = 1'b1; sn_cmd = c; sn_addr = a;
    #1;
    chk({rq, " sn_shared"}, int'(sn_shared), int'(exp_sh));
    chk({rq, " sn_flush"}, int'(sn_flush), int'(exp_fl));
    if (exp_fl) chk({rq, " sn_data"}, int'(sn_data), int'(exp_d));
    if (sn_flush) mem[a] = sn_data;
    @(negedge clk);
    sn_valid = 1'b0;
  endtask

  task automatic tx1(input string rq, input logic [2:0] c, input logic [7:0] a);
    chk({rq, " transaction count"}, n_tx, 1);
    chk({rq, " bus command"}, int'(lg_cmd[0]), int'(c));
    chk({rq, " bus address"}, int'(lg_addr[0]), int'(a));
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 8'(k * 5 + 17);
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    bm_gnt = 1'b0; bm_rdata = '0; bm_shared_in = 1'b0;
    sn_valid = 1'b0; sn_cmd = '0; sn_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: nothing valid after reset
    chk("R1 cpu_done at reset", int'(cpu_done), 0);
    chk("R1 bm_req at reset", int'(bm_req), 0);
    for (int i = 0; i < 4; i++) begin
      snoop(C_RD, 8'(i * 4 + i), 1'b0, 1'b0, 8'h00, "R1");
      snoop(C_RDX, 8'(i * 4 + i), 1'b0, 1'b0, 8'h00, "R1");
    end

    for (int i = 0; i < 4; i++) begin
      logic [7:0] a, b, c, d1, d2, d3, d4;
      a  = 8'((i + 3) * 4 + i);
      b  = 8'((i + 20) * 4 + i);
      c  = 8'((i + 40) * 4 + i);
      d1 = 8'(8'hA0 + i); d2 = 8'(8'hB0 + i); d3 = 8'(8'hC0 + i); d4 = 8'(8'hD0 + i);

      cpu_op(1'b0, a, 8'h00, 1'b0);
      tx1("R1 R2 read miss", C_RD, a);
      chk("R2 fill data", int'(last_rd), int'(mem[a]));
      cpu_op(1'b1, a, d1, 1'b0);
      chk("R5 write hit exclusive no bus", n_tx, 0);
      cpu_op(1'b0, a, 8'h00, 1'b0);
      chk("R7 read hit no bus", n_tx, 0);
      chk("R7 read hit data", int'(last_rd), int'(d1));
      snoop(C_RD, a, 1'b1, 1'b1, d1, "R8");
      cpu_op(1'b1, a, d2, 1'b0);
      tx1("R8 R6 upgrade after remote read", C_INV, a);
      cpu_op(1'b0, a, 8'h00, 1'b0);
      chk("R7 read hit modified no bus", n_tx, 0);
      snoop(C_RDX, a, 1'b0, 1'b1, d2, "R10");
      cpu_op(1'b0, a, 8'h00, 1'b1);
      tx1("R10 refetch after invalidate", C_RD, a);
      chk("R3 R10 fill returns flushed data", int'(last_rd), int'(d2));
      snoop(C_RD, a, 1'b1, 1'b0, 8'h00, "R9 shared line");
      snoop(C_INV, b, 1'b0, 1'b0, 8'h00, "R12 tag mismatch");
      snoop(C_WR, a, 1'b0, 1'b0, 8'h00, "R12 remote write");
      cpu_op(1'b0, a, 8'h00, 1'b0);
      chk("R12 line still valid", n_tx, 0);
      cpu_op(1'b1, a, d3, 1'b0);
      tx1("R3 R6 write to shared", C_INV, a);
      cpu_op(1'b0, b, 8'h00, 1'b0);
      chk("R11 transaction count", n_tx, 2);
      chk("R11 victim write command", int'(lg_cmd[0]), int'(C_WR));
      chk("R11 victim address", int'(lg_addr[0]), int'(a));
      chk("R11 victim data", int'(lg_data[0]), int'(d3));
      chk("R11 fill command after write-back", int'(lg_cmd[1]), int'(C_RD));
      chk("R11 fill address", int'(lg_addr[1]), int'(b));
      snoop(C_RD, b, 1'b1, 1'b0, 8'h00, "R9 exclusive line");
      cpu_op(1'b1, b, d4, 1'b0);
      tx1("R9 exclusive became shared", C_INV, b);
      cpu_op(1'b1, c, d1, 1'b0);
      chk("R4 R11 transaction count", n_tx, 2);
      chk("R11 victim write", int'(lg_cmd[0]), int'(C_WR));
      chk("R11 victim data", int'(lg_data[0]), int'(d4));
      chk("R4 write miss command", int'(lg_cmd[1]), int'(C_RDX));
      chk("R4 write miss address", int'(lg_addr[1]), int'(c));
      snoop(C_RD, c, 1'b1, 1'b1, d1, "R4 filled modified");
      snoop(C_INV, c, 1'b0, 1'b0, 8'h00, "R10 shared invalidated");
      cpu_op(1'b0, c, 8'h00, 1'b0);
      tx1("R10 miss after invalidate", C_RD, c);
      snoop(C_RDX, c, 1'b0, 1'b0, 8'h00, "R10 exclusive invalidated");
      cpu_op(1'b1, c, d2, 1'b0);
      tx1("R4 R10 write miss", C_RDX, c);
    end

    // R13: upgrade pending when a remote invalidate takes the copy
    begin
      logic [7:0] x;
      x = 8'h81;
      cpu_op(1'b0, x, 8'h00, 1'b1);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = x; cpu_wdata = 8'h5A;
      @(negedge clk);
      cpu_req = 1'b0;
      #1;
      chk("R6 pending upgrade request", int'(bm_req), 1);
      chk("R6 pending upgrade command", int'(bm_cmd), int'(C_INV));
      sn_valid = 1'b1; sn_cmd = C_INV; sn_addr = x;
      #1;
      chk("R13 request held during snoop", int'(bm_req), 0);
      @(negedge clk);
      sn_valid = 1'b0;
      #1;
      chk("R13 request back", int'(bm_req), 1);
      chk("R13 reissued as read-and-invalidate", int'(bm_cmd), int'(C_RDX));
      bm_gnt = 1'b1; bm_rdata = mem[x]; bm_shared_in = 1'b0;
      @(negedge clk);
      bm_gnt = 1'b0;
      chk("R13 completion", int'(cpu_done), 1);
      snoop(C_RD, x, 1'b1, 1'b1, 8'h5A, "R13 line modified");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule